// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block gathers nine level-sensitive interrupt inputs and drives three interrupt request outputs. Each input first passes through a two-flop synchroniser. It is then corrected for polarity, so that an asserted source always appears as a logic one inside the block. Each output line has its own register word. The low half of that word holds an enable mask that decides which sources reach the line. The upper half holds the line's latched pending flags, and software acknowledges a flag by writing a one to it. Because every line keeps its own pending copy, a source can be routed to several lines and acknowledged on each of them separately.

Software reaches the block through a simple synchronous 32-bit port with word addressing. Offset 0x0 is the polarity word. Offsets 0x4, 0x8 and 0xC belong to lines 0, 1 and 2. Three of the sources have a hardwired polarity: sources 1 and 8 are active-high and source 2 is active-low. The other sources take their polarity from software.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every irq_req bit is 0. Every line word reads 0. The polarity word reads 0x00000102, meaning the hardwired active-high bits 1 and 8 are set and every configurable source is active-low.
- R2: At offset 0x0, bit k (k = 0, 3..7) selects the polarity of source k, where 1 means active-high and 0 means active-low. The bit takes the written value and reads it back.
- R3: Polarity bits 1 and 8 always read 1 and bit 2 always reads 0, whatever value is written to them.
- R4: Bits [24:16] of the word for line n (offset 0x4+4n) are pending flags. Bit 16+k sets whenever source k is in its active state, whether or not the source is enabled, and stays set until it is acknowledged. A change on a source pin shows in the pending flag, and in irq_req, after three rising clock edges.
- R5: irq_req[n] is 1 exactly when some source k has both enable bit k (bits [8:0]) and pending bit 16+k set in line n's word.
- R6: Writing 1 to pending bit 16+k clears that flag. Writing 0 to it leaves the flag unchanged. Enable bits [8:0] take the written value.
- R7: If a source is still active when its pending flag is acknowledged, the flag stays set.
- R8: Writing 0x01FF0000 to a line word clears all of that line's enables and all of its inactive pending flags in that one write.
- R9: Bits 9..15 and 25..31 of every word read 0. Offsets above 0xC read 0, and writes to them change nothing.
- R10: The three lines hold separate enables and pending flags. A write to one line does not change another line, and one source can raise several lines at once.
- R11: A read returns the addressed word on bus_rdata one clock edge after the access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 9 | Raw interrupt source pins |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 3 | Interrupt request outputs, active high |

## Verification
Three results have different latencies, and the bench samples each one on the falling edge that follows its last register stage:
- A register write takes effect at the rising edge that accepts it.
- Read data shows up on bus_rdata one edge after the access.
- A change on a source pin needs three rising edges before irq_req reflects it: two for the synchroniser and one for the pending flag.

Every table step that changes a source pin therefore waits three edges before it compares irq_req. A separate directed test confirms that the output is still low after only two edges. Reads are counted as one-edge steps, and the expected pending values account for flags that set in the cycles between neighbouring steps.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int N_SRC    = 9,
  parameter int N_LINE   = 3,
  parameter int ADDR_W   = 8,
  parameter logic [N_SRC-1:0] POL_FIXED_MASK = 9'b1_0000_0110,
  parameter logic [N_SRC-1:0] POL_FIXED_VAL  = 9'b1_0000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_LINE-1:0] irq_req
);

  localparam int PEND_LSB = 16;
  localparam int WIDX_W   = ADDR_W - 2;
  localparam logic [N_SRC-1:0] POL_RST = POL_FIXED_VAL & POL_FIXED_MASK;

  logic [WIDX_W-1:0] widx;
  logic [N_SRC-1:0]  pol_q, sync1_q, sync2_q, active;
  logic [N_SRC-1:0]  en_q   [N_LINE];
  logic [N_SRC-1:0]  pend_q [N_LINE];
  logic [31:0]       rd_word;
  logic              wr_any, oob, unused_bits;

  assign widx        = bus_addr[ADDR_W-1:2];
  assign wr_any      = bus_sel & bus_we;
  assign oob         = widx > WIDX_W'(N_LINE);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= ~POL_RST;
      sync2_q <= ~POL_RST;
    end else begin
      sync1_q <= irq_src;
      sync2_q <= sync1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pol_q <= POL_RST;
    else if (wr_any && widx == '0)
      pol_q <= (bus_wdata[N_SRC-1:0] & ~POL_FIXED_MASK) | POL_RST;

  assign active = ~(sync2_q ^ pol_q);

  for (genvar n = 0; n < N_LINE; n++) begin : g_line
    logic             wr_line;
    logic [N_SRC-1:0] ack;

    assign wr_line = wr_any && widx == WIDX_W'(n + 1);
    assign ack     = wr_line ? bus_wdata[PEND_LSB +: N_SRC] : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en_q[n]   <= '0;
        pend_q[n] <= '0;
      end else begin
        if (wr_line) en_q[n] <= bus_wdata[N_SRC-1:0];
        pend_q[n] <= (pend_q[n] & ~ack) | active;
      end

    assign irq_req[n] = |(en_q[n] & pend_q[n]);

    p_pend_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_q[n] & $past(active)) == $past(active));

    p_req_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[n] == '0) |-> !irq_req[n]);

    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_line && bus_wdata[PEND_LSB +: N_SRC] == '1 && bus_wdata[N_SRC-1:0] == '0)
      |=> (en_q[n] == '0) && ((pend_q[n] & ~$past(active)) == '0));
  end

  always_comb begin
    rd_word = '0;
    if (widx == '0) rd_word[N_SRC-1:0] = pol_q;
    for (int n = 0; n < N_LINE; n++)
      if (widx == WIDX_W'(n + 1)) begin
        rd_word[N_SRC-1:0]          = en_q[n];
        rd_word[PEND_LSB +: N_SRC]  = pend_q[n];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_sel && !bus_we)
      bus_rdata <= rd_word;

  p_fixed_pol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pol_q ^ POL_FIXED_VAL) & POL_FIXED_MASK) == '0);

  p_oob_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && oob) |=> $stable(pol_q));

  p_oob_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && oob) |=> bus_rdata == '0);

endmodule

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;

  localparam logic [8:0] IDLE = 9'h0FD;
  localparam int NV = 43;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_S = 2'd2;

  // {op, addr, data/src, expected, requirement number}
  localparam logic [81:0] VEC [NV] = '{
    {OP_R, 8'h00, 32'h0,        32'h00000102, 8'd1},  // R1
    {OP_R, 8'h04, 32'h0,        32'h00000000, 8'd1},  // R1
    {OP_W, 8'h00, 32'hFFFFFFFF, 32'h0,        8'd2},
    {OP_R, 8'h00, 32'h0,        32'h000001FB, 8'd2},  // R2 R3
    {OP_W, 8'h00, 32'h0,        32'h0,        8'd2},
    {OP_R, 8'h04, 32'h0,        32'h00F90000, 8'd4},  // R4 latched
    {OP_R, 8'h00, 32'h0,        32'h00000102, 8'd3},  // R3
    {OP_W, 8'h04, 32'h01FF0000, 32'h0,        8'd8},
    {OP_R, 8'h04, 32'h0,        32'h00000000, 8'd8},  // R8
    {OP_R, 8'h08, 32'h0,        32'h00F90000, 8'd10}, // R10
    {OP_W, 8'h08, 32'h01FF0000, 32'h0,        8'd8},
    {OP_W, 8'h0C, 32'h01FF0000, 32'h0,        8'd8},
    {OP_W, 8'h04, 32'h00000001, 32'h0,        8'd5},
    {OP_S, 8'h00, 32'h000000FC, 32'h1,        8'd5},  // R5
    {OP_R, 8'h08, 32'h0,        32'h00010000, 8'd4},  // R4 no enable
    {OP_R, 8'h04, 32'h0,        32'h00010001, 8'd11}, // R11
    {OP_S, 8'h00, 32'h000000FD, 32'h1,        8'd4},  // R4 hold
    {OP_W, 8'h04, 32'h00010001, 32'h0,        8'd6},
    {OP_R, 8'h04, 32'h0,        32'h00000001, 8'd6},  // R6
    {OP_S, 8'h00, 32'h000000FD, 32'h0,        8'd5},  // R5
    {OP_S, 8'h00, 32'h000000FC, 32'h1,        8'd5},
    {OP_W, 8'h04, 32'h00010001, 32'h0,        8'd7},
    {OP_R, 8'h04, 32'h0,        32'h00010001, 8'd7},  // R7
    {OP_S, 8'h00, 32'h000000FD, 32'h1,        8'd7},
    {OP_W, 8'h04, 32'h00010001, 32'h0,        8'd6},
    {OP_S, 8'h00, 32'h000000FD, 32'h0,        8'd6},  // R6
    {OP_W, 8'h08, 32'h00000000, 32'h0,        8'd6},
    {OP_R, 8'h08, 32'h0,        32'h00010000, 8'd6},  // R6 zero keeps
    {OP_W, 8'h0C, 32'h00000100, 32'h0,        8'd10},
    {OP_S, 8'h00, 32'h000001FD, 32'h4,        8'd10}, // R10
    {OP_S, 8'h00, 32'h000000FD, 32'h4,        8'd4},
    {OP_W, 8'h0C, 32'h01FF0000, 32'h0,        8'd8},
    {OP_S, 8'h00, 32'h000000FD, 32'h0,        8'd8},  // R8
    {OP_S, 8'h00, 32'h000000F5, 32'h0,        8'd5},
    {OP_W, 8'h00, 32'h00000008, 32'h0,        8'd2},
    {OP_W, 8'h04, 32'h01FF0008, 32'h0,        8'd2},
    {OP_R, 8'h04, 32'h0,        32'h00000008, 8'd2},  // R2
    {OP_S, 8'h00, 32'h000000FD, 32'h1,        8'd2},
    {OP_W, 8'h10, 32'hFFFFFFFF, 32'h0,        8'd9},
    {OP_R, 8'h10, 32'h0,        32'h00000000, 8'd9},  // R9
    {OP_R, 8'h00, 32'h0,        32'h0000010A, 8'd9},
    {OP_W, 8'h04, 32'hFE00FE08, 32'h0,        8'd9},
    {OP_R, 8'h04, 32'h0,        32'h00080008, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  irq_src = IDLE;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_req;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; irq_src = IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check({29'b0, irq_req}, 32'h0, 1);  // R1

    foreach (VEC[i]) begin
      logic [1:0]  op   = VEC[i][81:80];
      logic [7:0]  a    = VEC[i][79:72];
      logic [31:0] d    = VEC[i][71:40];
      logic [31:0] e    = VEC[i][39:8];
      int          req  = int'(VEC[i][7:0]);
      case (op)
        OP_W: acc(1'b1, a, d);
        OP_R: begin acc(1'b0, a, 32'h0); check(bus_rdata, e, req); end
        default: begin
          irq_src = d[8:0];
          repeat (3) @(negedge clk);
          check({29'b0, irq_req}, e, req);
        end
      endcase
    end

    // R1: reset in mid-operation restores the reset state
    do_reset();
    check({29'b0, irq_req}, 32'h0, 1);
    acc(1'b0, 8'h00, 32'h0); check(bus_rdata, 32'h00000102, 1);
    acc(1'b0, 8'h04, 32'h0); check(bus_rdata, 32'h00000000, 1);

    // R4: three-edge latency from source pin to request
    acc(1'b1, 8'h04, 32'h00000001);
    irq_src = 9'h0FC;
    repeat (2) @(negedge clk);
    check({29'b0, irq_req}, 32'h0, 4);
    @(negedge clk);
    check({29'b0, irq_req}, 32'h1, 4);

    // R10: one source raises all lines, acked separately
    acc(1'b1, 8'h08, 32'h00000001);
    acc(1'b1, 8'h0C, 32'h00000001);
    check({29'b0, irq_req}, 32'h7, 10);
    irq_src = IDLE;
    repeat (3) @(negedge clk);
    acc(1'b1, 8'h08, 32'h00010001);
    check({29'b0, irq_req}, 32'h5, 10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule